// File: doc/BRIEF.md
# Byte Lane Access Sequencer

This block sits between a processor core that makes byte and word accesses and a 16-bit local data bus. For each request it picks the data-bus lanes with a low address bit and an active-low high-byte enable. Write bytes are steered onto the lane that matches the address, and read bytes are brought back down to bits 7..0. It returns one response per request. A word at an odd address does not fit in one bus operation, so the block splits it into two byte operations one after the other. The requester still sees a single request and a single response.

Requests arrive on a valid/ready stream. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. While `req_ready` is low, the requester holds its request unchanged. Responses leave on a second valid/ready stream. Once `rsp_valid` is high, it stays high with `rsp_rdata` unchanged until an edge where `rsp_ready` is also high. The same edge that completes a response may also accept the next request, so back-pressure on the response side stalls the request side.

On the bus side there is one handshake per bus operation. The block holds `bus_req` high, with stable address, lanes and write data, until a downstream bus-cycle engine pulses `bus_done`. The engine supplies read data on `bus_rdata` in the same cycle as `bus_done`. Memory and I/O requests follow the same lane rules. Only the address width differs: 16 bits for I/O, 20 bits for memory in real mode and 24 bits for memory in protected mode. The mode pin `real_mode` must not change while a request is in flight.

Top module: `byte_lane_seq`

## Requirements
- R1: A byte access at an even address is issued as one bus operation. The operation drives `bus_a0`=0 and `bus_bhe_n`=1. A write byte goes on bits 7..0 with bits 15..8 zero. A read returns `bus_rdata[7:0]` zero-extended to 16 bits.
- R2: A byte access at an odd address is issued as one bus operation. The operation drives `bus_a0`=1 and `bus_bhe_n`=0. A write byte (`req_wdata[7:0]`) goes on bits 15..8 with bits 7..0 zero. A read returns `bus_rdata[15:8]` moved to bits 7..0, with the upper byte zero.
- R3: A word access at an even address is issued as one bus operation with `bus_a0`=0 and `bus_bhe_n`=0. Write data passes unchanged, and read data is returned unchanged. The low byte is at the lower address.
- R4: A word access at an odd address A is issued as two bus operations in order.
  - The first operation is at A with `bus_a0`=1 and `bus_bhe_n`=0. It carries `req_wdata[7:0]` on bits 15..8.
  - The second operation is at A+1 with `bus_a0`=0 and `bus_bhe_n`=1. It carries `req_wdata[15:8]` on bits 7..0.
  - Read data is returned as {second `bus_rdata[7:0]`, first `bus_rdata[15:8]`}.
- R5: `rsp_valid` rises only after the `bus_done` of the last bus operation of a request, in the following cycle. There is exactly one response per request. `rsp_valid` and `rsp_rdata` hold until accepted.
- R6: The request address is masked to 16 bits for I/O (`req_io`=1), to 20 bits for memory when `real_mode`=1, and to 24 bits otherwise. The A+1 of R4 wraps within the same width.
- R7: `bus_req` stays high, with address, lane enables and write data stable, until `bus_done`. `bus_write` and `bus_io` copy the request's `req_write` and `req_io`. `bus_req` is low after reset.
- R8: `req_ready` is high in idle, and also in a response cycle where `rsp_ready` is high. In all other cases it is low. An accepted request raises `bus_req` in the next cycle. `req_ready` is high after reset.
- R9: On writes, the byte lane not selected is driven to zero. The response to a write carries `rsp_rdata`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| real_mode | input | 1 | 1 selects 20-bit memory addressing, 0 selects 24-bit |
| req_valid | input | 1 | Request stream valid |
| req_ready | output | 1 | Request stream ready |
| req_write | input | 1 | 1 = write, 0 = read |
| req_word | input | 1 | 1 = word access, 0 = byte access |
| req_io | input | 1 | 1 = I/O space, 0 = memory space |
| req_addr | input | ADDR_W | Byte address of the request |
| req_wdata | input | DATA_W | Write data; a byte uses bits 7..0 |
| rsp_valid | output | 1 | Response stream valid |
| rsp_ready | input | 1 | Response stream ready |
| rsp_rdata | output | DATA_W | Assembled read data, or zero for writes |
| bus_req | output | 1 | Bus operation requested |
| bus_done | input | 1 | Bus operation finished (one-cycle pulse) |
| bus_addr_hi | output | ADDR_W-1 | Bus address bits ADDR_W-1..1 |
| bus_a0 | output | 1 | Bus address bit 0 (low-lane select, active low) |
| bus_bhe_n | output | 1 | High-byte enable, active low |
| bus_write | output | 1 | Operation direction |
| bus_io | output | 1 | Operation address space |
| bus_wdata | output | DATA_W | Lane-steered write data |
| bus_rdata | input | DATA_W | Read data, valid with bus_done |

## Verification
Two things can happen on the same edge: the handshake that hands out a finished response, and the acceptance of the next request. To provoke this, the bench keeps the next request valid while a response is pending, and it drives `rsp_ready` with an irregular pattern. The bench counts edges where both handshakes fire. It requires that such edges occur, and that the response taken on that edge belongs to the older request. It also requires that the bus operations of the new request appear afterwards in the right order. Bus latencies vary from zero to two wait cycles, so the second half of a split word sometimes follows its first half with no idle cycle between them.

// File: rtl/blseq_pkg.sv
package blseq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_OP1  = 2'd1,
    ST_OP2  = 2'd2,
    ST_RESP = 2'd3
  } blseq_state_e;

  typedef struct packed {
    logic write;
    logic word;
    logic io;
    logic real_m;
  } blseq_kind_t;

endpackage

// File: rtl/blseq_addr.sv
module blseq_addr #(
  parameter int ADDR_W = 24,
  parameter int REAL_W = 20,
  parameter int IO_W   = 16
) (
  input  logic [ADDR_W-1:0] addr_raw,
  input  logic              io,
  input  logic              real_m,
  output logic [ADDR_W-1:0] addr_base,
  output logic [ADDR_W-1:0] addr_next
);

  localparam logic [ADDR_W-1:0] MASK_FULL = {ADDR_W{1'b1}};
  localparam logic [ADDR_W-1:0] MASK_REAL = {{(ADDR_W-REAL_W){1'b0}}, {REAL_W{1'b1}}};
  localparam logic [ADDR_W-1:0] MASK_IO   = {{(ADDR_W-IO_W){1'b0}}, {IO_W{1'b1}}};
  localparam logic [ADDR_W-1:0] ONE       = {{(ADDR_W-1){1'b0}}, 1'b1};

  logic [ADDR_W-1:0] mask;

  always_comb begin
    if (io)          mask = MASK_IO;
    else if (real_m) mask = MASK_REAL;
    else             mask = MASK_FULL;
  end

  // Base address of the access, and the following byte address wrapped
  // inside the space selected above.
  assign addr_base = addr_raw & mask;
  assign addr_next = (addr_base + ONE) & mask;

endmodule

// File: rtl/blseq_lane.sv
module blseq_lane #(
  parameter int DATA_W = 16
) (
  input  logic              phase2,
  input  logic              word,
  input  logic              odd,
  input  logic [DATA_W-1:0] wdata,
  output logic              bhe_n,
  output logic              split,
  output logic [DATA_W-1:0] bus_wdata
);

  localparam int LANE_W = DATA_W / 2;
  localparam logic [LANE_W-1:0] ZB = '0;

  logic [LANE_W-1:0] lo_b;
  logic [LANE_W-1:0] hi_b;

  assign lo_b  = wdata[LANE_W-1:0];
  assign hi_b  = wdata[DATA_W-1:LANE_W];
  assign split = word & odd;

  always_comb begin
    bhe_n     = 1'b1;
    bus_wdata = '0;
    unique case ({word, odd})
      2'b00: begin
        bhe_n     = 1'b1;
        bus_wdata = {ZB, lo_b};
      end
      2'b01: begin
        bhe_n     = 1'b0;
        bus_wdata = {lo_b, ZB};
      end
      2'b10: begin
        bhe_n     = 1'b0;
        bus_wdata = wdata;
      end
      default: begin
        if (phase2) begin
          // high byte of the word, even address, low lane
          bhe_n     = 1'b1;
          bus_wdata = {ZB, hi_b};
        end else begin
          // low byte of the word, odd address, high lane
          bhe_n     = 1'b0;
          bus_wdata = {lo_b, ZB};
        end
      end
    endcase
  end

endmodule

// File: rtl/blseq_gather.sv
module blseq_gather #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              cap,
  input  logic              phase2,
  input  logic              word,
  input  logic              odd,
  input  logic              write,
  input  logic [DATA_W-1:0] bus_rdata,
  output logic [DATA_W-1:0] rdata
);

  localparam int LANE_W = DATA_W / 2;
  localparam logic [LANE_W-1:0] ZB = '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata <= '0;
    end else if (clr) begin
      rdata <= '0;
    end else if (cap && !write) begin
      unique case ({word, odd})
        2'b00: rdata <= {ZB, bus_rdata[LANE_W-1:0]};
        2'b01: rdata <= {ZB, bus_rdata[DATA_W-1:LANE_W]};
        2'b10: rdata <= bus_rdata;
        default: begin
          if (phase2) rdata[DATA_W-1:LANE_W] <= bus_rdata[LANE_W-1:0];
          else        rdata[LANE_W-1:0]      <= bus_rdata[DATA_W-1:LANE_W];
        end
      endcase
    end
  end

endmodule

// File: rtl/blseq_ctrl.sv
module blseq_ctrl
  import blseq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic rsp_ready,
  input  logic bus_done,
  input  logic split,
  output logic req_ready,
  output logic accept,
  output logic bus_req,
  output logic phase2,
  output logic cap,
  output logic rsp_valid
);

  blseq_state_e state_q, state_d;

  assign req_ready = (state_q == ST_IDLE) || ((state_q == ST_RESP) && rsp_ready);
  assign accept    = req_valid && req_ready;
  assign bus_req   = (state_q == ST_OP1) || (state_q == ST_OP2);
  assign phase2    = (state_q == ST_OP2);
  assign cap       = bus_req && bus_done;
  assign rsp_valid = (state_q == ST_RESP);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (accept) state_d = ST_OP1;
      ST_OP1:  if (bus_done) state_d = split ? ST_OP2 : ST_RESP;
      ST_OP2:  if (bus_done) state_d = ST_RESP;
      default: begin
        if (rsp_ready) state_d = accept ? ST_OP1 : ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

endmodule

// File: rtl/byte_lane_seq.sv
module byte_lane_seq
  import blseq_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int REAL_W = 20,
  parameter int IO_W   = 16,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              real_mode,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic              req_word,
  input  logic              req_io,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              bus_req,
  input  logic              bus_done,
  output logic [ADDR_W-1:1] bus_addr_hi,
  output logic              bus_a0,
  output logic              bus_bhe_n,
  output logic              bus_write,
  output logic              bus_io,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] bus_rdata
);

  logic              accept;
  logic              phase2;
  logic              cap;
  logic              split;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  blseq_kind_t       kind_q;
  logic [ADDR_W-1:0] addr_base;
  logic [ADDR_W-1:0] addr_next;
  logic [ADDR_W-1:0] addr_sel;

  // Request capture
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      kind_q  <= '0;
    end else if (accept) begin
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
      kind_q  <= '{write: req_write, word: req_word, io: req_io, real_m: real_mode};
    end
  end

  blseq_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .rsp_ready (rsp_ready),
    .bus_done  (bus_done),
    .split     (split),
    .req_ready (req_ready),
    .accept    (accept),
    .bus_req   (bus_req),
    .phase2    (phase2),
    .cap       (cap),
    .rsp_valid (rsp_valid)
  );

  blseq_addr #(
    .ADDR_W (ADDR_W),
    .REAL_W (REAL_W),
    .IO_W   (IO_W)
  ) u_addr (
    .addr_raw  (addr_q),
    .io        (kind_q.io),
    .real_m    (kind_q.real_m),
    .addr_base (addr_base),
    .addr_next (addr_next)
  );

  blseq_lane #(
    .DATA_W (DATA_W)
  ) u_lane (
    .phase2    (phase2),
    .word      (kind_q.word),
    .odd       (addr_base[0]),
    .wdata     (wdata_q),
    .bhe_n     (bus_bhe_n),
    .split     (split),
    .bus_wdata (bus_wdata)
  );

  blseq_gather #(
    .DATA_W (DATA_W)
  ) u_gather (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (accept),
    .cap       (cap),
    .phase2    (phase2),
    .word      (kind_q.word),
    .odd       (addr_base[0]),
    .write     (kind_q.write),
    .bus_rdata (bus_rdata),
    .rdata     (rsp_rdata)
  );

  assign addr_sel    = phase2 ? addr_next : addr_base;
  assign bus_addr_hi = addr_sel[ADDR_W-1:1];
  assign bus_a0      = addr_sel[0];
  assign bus_write   = kind_q.write;
  assign bus_io      = kind_q.io;

endmodule

// File: rtl/blseq_checker.sv
module blseq_checker #(
  parameter int ADDR_W = 24,
  parameter int REAL_W = 20,
  parameter int IO_W   = 16,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              real_mode,
  input logic              req_valid,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [DATA_W-1:0] rsp_rdata,
  input logic              bus_req,
  input logic              bus_done,
  input logic [ADDR_W-1:1] bus_addr_hi,
  input logic              bus_a0,
  input logic              bus_bhe_n,
  input logic              bus_write,
  input logic              bus_io,
  input logic [DATA_W-1:0] bus_wdata
);

  localparam int LANE_W = DATA_W / 2;

  // R1 R2 R3 R4: no operation leaves both lanes unselected
  a_r2_some_lane: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |-> !(bus_a0 && bus_bhe_n));

  // R7
  a_r7_bus_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_done) |=> (bus_req && $stable(bus_addr_hi) && $stable(bus_a0)
      && $stable(bus_bhe_n) && $stable(bus_wdata) && $stable(bus_write) && $stable(bus_io)));

  // R5
  a_r5_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata)));

  a_r5_rsp_not_during_bus: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !bus_req);

  // R8
  a_r8_accept_starts_bus: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> bus_req);

  a_r8_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |-> !req_ready);

  // R6
  a_r6_real_width: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && real_mode && !bus_io) |-> (bus_addr_hi[ADDR_W-1:REAL_W] == '0));

  a_r6_io_width: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_io) |-> (bus_addr_hi[ADDR_W-1:IO_W] == '0));

  // R9
  a_r9_idle_hi_lane: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_write && bus_bhe_n) |-> (bus_wdata[DATA_W-1:LANE_W] == '0));

  a_r9_idle_lo_lane: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_write && bus_a0) |-> (bus_wdata[LANE_W-1:0] == '0));

endmodule

bind byte_lane_seq blseq_checker #(
  .ADDR_W (ADDR_W),
  .REAL_W (REAL_W),
  .IO_W   (IO_W),
  .DATA_W (DATA_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .real_mode   (real_mode),
  .req_valid   (req_valid),
  .req_ready   (req_ready),
  .rsp_valid   (rsp_valid),
  .rsp_ready   (rsp_ready),
  .rsp_rdata   (rsp_rdata),
  .bus_req     (bus_req),
  .bus_done    (bus_done),
  .bus_addr_hi (bus_addr_hi),
  .bus_a0      (bus_a0),
  .bus_bhe_n   (bus_bhe_n),
  .bus_write   (bus_write),
  .bus_io      (bus_io),
  .bus_wdata   (bus_wdata)
);

// File: tb/tb_byte_lane_seq.sv
module tb_byte_lane_seq;

  localparam int AW = 24;

  typedef struct {
    logic [AW-1:0] addr;
    logic          bhe_n;
    logic          wr;
    logic          io;
    logic [15:0]   wd;
    string         tag;
  } op_t;

  typedef struct {
    logic [15:0] rd;
    int          ops_end;
    string       tag;
  } rsp_t;

  logic          clk = 0;
  logic          rst_n = 0;
  logic          real_mode = 0;
  logic          req_valid = 0;
  logic          req_ready;
  logic          req_write = 0;
  logic          req_word = 0;
  logic          req_io = 0;
  logic [AW-1:0] req_addr = '0;
  logic [15:0]   req_wdata = '0;
  logic          rsp_valid;
  logic          rsp_ready = 0;
  logic [15:0]   rsp_rdata;
  logic          bus_req;
  logic          bus_done = 0;
  logic [AW-1:1] bus_addr_hi;
  logic          bus_a0;
  logic          bus_bhe_n;
  logic          bus_write;
  logic          bus_io;
  logic [15:0]   bus_wdata;
  logic [15:0]   bus_rdata = '0;

  int checks = 0;
  int errors = 0;
  int ops_issued = 0;
  int ops_served = 0;
  int overlaps = 0;
  op_t  oq[$];
  rsp_t rq[$];

  always #10 clk = ~clk;

  byte_lane_seq dut (
    .clk(clk), .rst_n(rst_n), .real_mode(real_mode),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_word(req_word), .req_io(req_io), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .bus_req(bus_req), .bus_done(bus_done), .bus_addr_hi(bus_addr_hi), .bus_a0(bus_a0),
    .bus_bhe_n(bus_bhe_n), .bus_write(bus_write), .bus_io(bus_io),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  function automatic logic [15:0] rd_of(input logic [AW-1:0] a);
    return {a[7:0] ^ 8'h3C, a[15:8] ^ a[7:0] ^ 8'h81};
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic push_op(input logic [AW-1:0] a, input logic bhe, input logic wr, input logic io,
                         input logic [15:0] wd, input string tag);
    op_t o;
    o.addr = a; o.bhe_n = bhe; o.wr = wr; o.io = io; o.wd = wd; o.tag = tag;
    oq.push_back(o);
    ops_issued++;
  endtask

  // Driver: computes expected bus operations and response, then offers the request
  task automatic issue(input logic wr, input logic wd_word, input logic io,
                       input logic [AW-1:0] a, input logic [15:0] w, input string tag);
    logic [AW-1:0] m, ma, m1;
    logic [15:0]   rdx;
    rsp_t r;
    bit acc;
    m  = io ? 24'h00FFFF : (real_mode ? 24'h0FFFFF : 24'hFFFFFF);
    ma = a & m;
    m1 = (ma + 24'd1) & m;
    if (!wd_word && !ma[0]) begin
      push_op(ma, 1'b1, wr, io, {8'h00, w[7:0]}, tag);
      rdx = {8'h00, rd_of(ma)[7:0]};
    end else if (!wd_word) begin
      push_op(ma, 1'b0, wr, io, {w[7:0], 8'h00}, tag);
      rdx = {8'h00, rd_of(ma)[15:8]};
    end else if (!ma[0]) begin
      push_op(ma, 1'b0, wr, io, w, tag);
      rdx = rd_of(ma);
    end else begin
      push_op(ma, 1'b0, wr, io, {w[7:0], 8'h00}, tag);
      push_op(m1, 1'b1, wr, io, {8'h00, w[15:8]}, tag);
      rdx = {rd_of(m1)[7:0], rd_of(ma)[15:8]};
    end
    r.rd = wr ? 16'h0000 : rdx;
    r.ops_end = ops_issued;
    r.tag = wr ? {tag, "/R9"} : tag;
    rq.push_back(r);
    @(negedge clk);
    req_valid = 1; req_write = wr; req_word = wd_word; req_io = io;
    req_addr = a; req_wdata = w;
    acc = 0;
    while (!acc) begin
      #2;
      acc = req_ready;
      @(posedge clk);
      if (!acc) @(negedge clk);
    end
  endtask

  task automatic drain();
    @(negedge clk);
    req_valid = 0;
    while (rq.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  // Bus-cycle engine model: compares each operation, answers after 0..2 waits
  initial begin
    int lat;
    op_t e;
    lat = 0;
    forever begin
      @(negedge clk);
      bus_done = 0;
      if (rst_n && bus_req) begin
        if (oq.size() == 0) begin
          check(0, "R5 unexpected bus operation", {8'h0, bus_addr_hi, bus_a0}, 32'h0);
        end else begin
          e = oq.pop_front();
          check({bus_addr_hi, bus_a0} == e.addr, {e.tag, " addr"}, {8'h0, bus_addr_hi, bus_a0}, {8'h0, e.addr});
          check(bus_bhe_n == e.bhe_n, {e.tag, " bhe_n"}, {31'h0, bus_bhe_n}, {31'h0, e.bhe_n});
          check({bus_write, bus_io} == {e.wr, e.io}, "R7 write/io copy", {30'h0, bus_write, bus_io}, {30'h0, e.wr, e.io});
          if (e.wr) check(bus_wdata == e.wd, {e.tag, "/R9 wdata"}, {16'h0, bus_wdata}, {16'h0, e.wd});
        end
        repeat (lat) @(negedge clk);
        lat = (lat + 1) % 3;
        bus_rdata = rd_of({bus_addr_hi, bus_a0});
        bus_done = 1;
        ops_served++;
      end
    end
  end

  // Response monitor with irregular back-pressure
  initial begin
    int mc;
    rsp_t e;
    mc = 0;
    forever begin
      @(negedge clk);
      rsp_ready = ((mc % 5) != 2) && ((mc % 7) != 4);
      mc++;
      #2;
      if (rst_n && rsp_valid && rsp_ready) begin
        if (req_valid && req_ready) overlaps++;
        if (rq.size() == 0) begin
          check(0, "R5 unexpected response", {16'h0, rsp_rdata}, 32'h0);
        end else begin
          e = rq.pop_front();
          check(rsp_rdata == e.rd, {e.tag, " rdata"}, {16'h0, rsp_rdata}, {16'h0, e.rd});
          check(ops_served == e.ops_end, "R5 response after final op", ops_served, e.ops_end);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    #2;
    check(req_ready == 1'b1, "R8 reset req_ready", {31'h0, req_ready}, 32'h1);
    check(bus_req == 1'b0, "R7 reset bus_req", {31'h0, bus_req}, 32'h0);
    check(rsp_valid == 1'b0, "R5 reset rsp_valid", {31'h0, rsp_valid}, 32'h0);

    // protected mode, memory
    issue(0, 0, 0, 24'h001234, 16'h0000, "R1");
    issue(0, 0, 0, 24'h001235, 16'h0000, "R2");
    issue(1, 0, 0, 24'h002000, 16'hBEA5, "R1");
    issue(1, 0, 0, 24'h002001, 16'hBE5A, "R2");
    issue(0, 1, 0, 24'h0A0010, 16'h0000, "R3");
    issue(1, 1, 0, 24'h0A0012, 16'hC0DE, "R3");
    issue(0, 1, 0, 24'h0A0013, 16'h0000, "R4");
    issue(1, 1, 0, 24'h0A0015, 16'h1357, "R4");
    issue(0, 1, 0, 24'h0B0021, 16'h0000, "R4");
    issue(1, 1, 0, 24'h0B0023, 16'h2468, "R4");
    issue(0, 1, 0, 24'hFFFFFF, 16'h0000, "R6 wrap24");
    issue(1, 1, 0, 24'hFFFFFF, 16'hA1B2, "R6 wrap24");
    // I/O space: 16-bit masking and wrap
    issue(0, 0, 1, 24'h120081, 16'h0000, "R6 io/R2");
    issue(1, 0, 1, 24'h340080, 16'h0077, "R6 io/R1");
    issue(0, 1, 1, 24'h12FFFF, 16'h0000, "R6 io wrap");
    issue(1, 1, 1, 24'h00FFFF, 16'h9ABC, "R6 io wrap");
    issue(0, 1, 1, 24'h560300, 16'h0000, "R6 io/R3");
    drain();

    real_mode = 1;
    issue(0, 1, 0, 24'hAFFFFF, 16'h0000, "R6 wrap20");
    issue(1, 1, 0, 24'h5FFFFF, 16'h7E81, "R6 wrap20");
    issue(0, 0, 0, 24'hC12345, 16'h0000, "R6 real/R2");
    issue(1, 1, 0, 24'h3ABCDE, 16'h4411, "R6 real/R3");
    issue(0, 1, 0, 24'h900777, 16'h0000, "R6 real/R4");
    drain();
    real_mode = 0;

    check(overlaps > 0, "R8 response and accept on one edge", overlaps, 1);
    check(oq.size() == 0, "R5 all bus operations issued", oq.size(), 0);
    check(ops_served == ops_issued, "R4 bus operation count", ops_served, ops_issued);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule